// File: doc/BRIEF.md
# Precise Exception Tracker for a Five-Stage Pipeline

This block is the exception control for an in-order pipeline with fetch, decode, execute, memory and write-back stages. Each stage holds one slot. A slot has a valid flag, the instruction's PC and a 3-bit cause code. A fault raised by any stage is written into the slot of the instruction that raised it and travels down the pipe with that instruction. Nothing acts on the fault until the slot reaches write-back. At that point the block takes the exception:

- it latches the slot's PC and cause,
- it steers fetch to a fixed vector address,
- it discards every younger slot.

Because faults are resolved only at write-back, the oldest faulting instruction always wins. This holds even when a younger instruction flagged its fault first.

An external interrupt is a level input. While it is high, the fetch slot is replaced by a no-op that already carries the interrupt cause. If a flush drops that no-op, the still-high level injects a new one. A slot that carries a cause blocks its own memory write and register write. Branches resolve in execute. An exception at write-back overrides a branch redirect in the same cycle.

Top module: `xcpt_tracker`

## Requirements
- R1: While reset is low, and in the first cycle after it, no exception is taken, no redirect is issued, no write is enabled, and the saved PC and saved cause are zero.
- R2: Cause codes are 3 bits: 0 none, 1 fetch translation fault, 2 illegal instruction, 3 arithmetic overflow, 4 data translation fault, 5 interrupt. When one instruction raises faults in several stages, the first one raised is kept and later ones are ignored.
- R3: `xc_take` is high exactly in the cycle when a valid slot with a nonzero cause sits in write-back. That cycle is the fourth clock edge after the slot was presented at fetch, counting the edge that captured it.
- R4: On the edge that ends a take cycle, `xc_epc` and `xc_cause` load the PC and cause of the write-back slot. At every other edge they hold their values.
- R5: In a take cycle, `redir_valid` is 1 and `redir_pc` equals the parameter VECTOR. This applies even if a branch resolves in the same cycle.
- R6: A take discards the slots in decode, execute, memory and write-back and drops the slot presented at fetch. In the next cycle there is no take and no write-back write.
- R7: When an older instruction faults at a later stage after a younger instruction has already faulted at an earlier stage, the older one is taken and the younger one never is.
- R8: While `irq_level` is 1, the fetch slot is a valid no-op with cause 5 and the PC on `if_pc`, whatever `if_valid` says. A flushed interrupt no-op is injected again on the next cycle in which the level is still high.
- R9: `wb_wr_ok` is 1 only for a valid fault-free write-back slot. `mem_wr_ok` is 1 only for a valid fault-free memory slot that has no data fault this cycle and is not behind a take.
- R10: A branch in a valid fault-free execute slot sets `redir_valid`, drives `redir_pc` to `ex_target`, and discards the fetch and decode slots. A branch in a faulted slot does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| if_valid | input | 1 | An instruction is presented at fetch |
| if_pc | input | PC_W | PC of the fetch slot |
| if_itlb_fault | input | 1 | Fetch translation fault for the fetch slot |
| irq_level | input | 1 | Level-held external interrupt |
| id_illegal | input | 1 | Decode reports an illegal instruction |
| ex_overflow | input | 1 | Execute reports arithmetic overflow |
| ex_branch | input | 1 | Execute resolves a taken branch |
| ex_target | input | PC_W | Branch target address |
| mem_dtlb_fault | input | 1 | Memory stage reports a data translation fault |
| mem_wr_ok | output | 1 | Memory-stage store may proceed |
| wb_wr_ok | output | 1 | Write-back register write may proceed |
| xc_take | output | 1 | An exception is taken this cycle |
| xc_epc | output | PC_W | Saved PC of the last taken exception |
| xc_cause | output | 3 | Saved cause of the last taken exception |
| redir_valid | output | 1 | Fetch must restart at redir_pc |
| redir_pc | output | PC_W | Fetch restart address |

## Verification
Suppose a slot register loses or overwrites its cause. The fault then reaches write-back late or not at all, so `xc_take` is missed or `wb_wr_ok` goes high for a faulted instruction. Either error shows at the ports four cycles after fetch.

A kill that misses a slot lets a wrong-path instruction reach write-back. It shows as an extra write or an extra take within four cycles of the flush.

Wrong cause merging or wrong age ordering shows as a wrong `xc_cause` or `xc_epc` one edge after the take. The bench runs a cycle-accurate reference model, so any of these faults is seen in the first cycle where the model and the design disagree.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;
   typedef enum logic [2:0] {
      XC_NONE = 3'd0,
      XC_ITLB = 3'd1,
      XC_ILL  = 3'd2,
      XC_OVF  = 3'd3,
      XC_DTLB = 3'd4,
      XC_IRQ  = 3'd5
   } xc_cause_e;

   // slots beyond fetch: decode, execute, memory, write-back
   localparam int N_SLOTS  = 4;
   // index of the slot array where branches resolve (0 = fetch)
   localparam int BR_STAGE = 2;

   // first raised cause sticks to an instruction
   function automatic xc_cause_e xc_merge(input xc_cause_e held, input xc_cause_e raised);
      return (held != XC_NONE) ? held : raised;
   endfunction
endpackage

// File: rtl/xcpt_slot.sv
module xcpt_slot
   import xcpt_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            flush,
   input  logic            kill,
   input  logic            in_valid,
   input  logic [PC_W-1:0] in_pc,
   input  xc_cause_e       in_cause,
   input  xc_cause_e       raise,
   output logic            out_valid,
   output logic [PC_W-1:0] out_pc,
   output xc_cause_e       out_cause
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_pc    <= '0;
         out_cause <= XC_NONE;
      end else if (flush || kill) begin
         out_valid <= 1'b0;
         out_cause <= XC_NONE;
      end else begin
         out_valid <= in_valid;
         out_pc    <= in_pc;
         out_cause <= in_valid ? xc_merge(in_cause, raise) : XC_NONE;
      end
   end
endmodule

// File: rtl/xcpt_commit.sv
module xcpt_commit
   import xcpt_pkg::*;
#(
   parameter int              PC_W   = 32,
   parameter logic [PC_W-1:0] VECTOR = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wb_valid,
   input  logic [PC_W-1:0] wb_pc,
   input  xc_cause_e       wb_cause,
   input  logic            br_ok,
   input  logic [PC_W-1:0] br_target,
   output logic            take,
   output logic [PC_W-1:0] epc,
   output logic [2:0]      cause,
   output logic            redir_valid,
   output logic [PC_W-1:0] redir_pc
);
   assign take        = wb_valid && (wb_cause != XC_NONE);
   assign redir_valid = take || br_ok;
   assign redir_pc    = take ? VECTOR : br_target;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         epc   <= '0;
         cause <= 3'd0;
      end else if (take) begin
         epc   <= wb_pc;
         cause <= wb_cause;
      end
   end
endmodule

// File: rtl/xcpt_tracker.sv
module xcpt_tracker
   import xcpt_pkg::*;
#(
   parameter int              PC_W   = 32,
   parameter logic [PC_W-1:0] VECTOR = 'h80
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            if_valid,
   input  logic [PC_W-1:0] if_pc,
   input  logic            if_itlb_fault,
   input  logic            irq_level,
   input  logic            id_illegal,
   input  logic            ex_overflow,
   input  logic            ex_branch,
   input  logic [PC_W-1:0] ex_target,
   input  logic            mem_dtlb_fault,
   output logic            mem_wr_ok,
   output logic            wb_wr_ok,
   output logic            xc_take,
   output logic [PC_W-1:0] xc_epc,
   output logic [2:0]      xc_cause,
   output logic            redir_valid,
   output logic [PC_W-1:0] redir_pc
);
   localparam int LAST = N_SLOTS;
   localparam int MEMS = N_SLOTS - 1;

   if (PC_W < 8) begin : g_bad_width
      $error("xcpt_tracker: PC_W must be at least 8");
   end
   if (VECTOR[1:0] != 2'b00) begin : g_bad_vector
      $error("xcpt_tracker: VECTOR must be word aligned");
   end

   // slot 0 is the fetch slot, slots 1..LAST are registered
   logic            sv  [0:LAST];
   logic [PC_W-1:0] spc [0:LAST];
   xc_cause_e       sc  [0:LAST];
   xc_cause_e       raise [0:LAST-1];
   logic            br_ok;

   assign sv[0]  = if_valid || irq_level;
   assign spc[0] = if_pc;
   assign sc[0]  = XC_NONE;

   assign raise[0] = irq_level ? XC_IRQ : (if_itlb_fault ? XC_ITLB : XC_NONE);
   assign raise[1] = id_illegal     ? XC_ILL  : XC_NONE;
   assign raise[2] = ex_overflow    ? XC_OVF  : XC_NONE;
   assign raise[3] = mem_dtlb_fault ? XC_DTLB : XC_NONE;

   assign br_ok = ex_branch && sv[BR_STAGE] && (sc[BR_STAGE] == XC_NONE);

   for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
      xcpt_slot #(.PC_W(PC_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .flush     (xc_take),
         .kill      (br_ok && (k < BR_STAGE)),
         .in_valid  (sv[k]),
         .in_pc     (spc[k]),
         .in_cause  (sc[k]),
         .raise     (raise[k]),
         .out_valid (sv[k+1]),
         .out_pc    (spc[k+1]),
         .out_cause (sc[k+1])
      );
   end

   xcpt_commit #(.PC_W(PC_W), .VECTOR(VECTOR)) u_commit (
      .clk         (clk),
      .rst_n       (rst_n),
      .wb_valid    (sv[LAST]),
      .wb_pc       (spc[LAST]),
      .wb_cause    (sc[LAST]),
      .br_ok       (br_ok),
      .br_target   (ex_target),
      .take        (xc_take),
      .epc         (xc_epc),
      .cause       (xc_cause),
      .redir_valid (redir_valid),
      .redir_pc    (redir_pc)
   );

   assign wb_wr_ok  = sv[LAST] && (sc[LAST] == XC_NONE);
   assign mem_wr_ok = sv[MEMS] && (sc[MEMS] == XC_NONE) && !mem_dtlb_fault && !xc_take;
endmodule

// File: rtl/xcpt_tracker_chk.sv
module xcpt_tracker_chk #(
   parameter int              PC_W   = 32,
   parameter logic [PC_W-1:0] VECTOR = 'h80
) (
   input logic            clk,
   input logic            rst_n,
   input logic            xc_take,
   input logic [PC_W-1:0] xc_epc,
   input logic [2:0]      xc_cause,
   input logic            redir_valid,
   input logic [PC_W-1:0] redir_pc,
   input logic            wb_wr_ok,
   input logic            mem_wr_ok
);
   // R5
   a_r5_vector: assert property (@(posedge clk) disable iff (!rst_n)
      xc_take |-> (redir_valid && redir_pc == VECTOR));
   // R4
   a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !xc_take |=> ($stable(xc_epc) && $stable(xc_cause)));
   // R4, R2
   a_r4_cause_set: assert property (@(posedge clk) disable iff (!rst_n)
      xc_take |=> (xc_cause != 3'd0 && xc_cause <= 3'd5));
   // R6
   a_r6_flush: assert property (@(posedge clk) disable iff (!rst_n)
      xc_take |=> (!xc_take && !wb_wr_ok));
   // R9
   a_r9_no_write_on_take: assert property (@(posedge clk) disable iff (!rst_n)
      xc_take |-> (!wb_wr_ok && !mem_wr_ok));
endmodule

bind xcpt_tracker xcpt_tracker_chk #(.PC_W(PC_W), .VECTOR(VECTOR)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .xc_take     (xc_take),
   .xc_epc      (xc_epc),
   .xc_cause    (xc_cause),
   .redir_valid (redir_valid),
   .redir_pc    (redir_pc),
   .wb_wr_ok    (wb_wr_ok),
   .mem_wr_ok   (mem_wr_ok)
);

// File: tb/xcpt_tracker_bench.sv
module xcpt_tracker_bench;
   localparam int          PC_W = 32;
   localparam logic [31:0] VEC  = 32'h80;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic if_valid = 0, if_itlb_fault = 0, irq_level = 0, id_illegal = 0;
   logic ex_overflow = 0, ex_branch = 0, mem_dtlb_fault = 0;
   logic [31:0] if_pc = 0, ex_target = 0;
   logic mem_wr_ok, wb_wr_ok, xc_take, redir_valid;
   logic [31:0] xc_epc, redir_pc;
   logic [2:0]  xc_cause;

   int checks = 0, fails = 0;
   bit done = 0;

   // reference model, index 1..4 = decode..write-back
   logic       mv [1:4];
   logic [31:0] mpc [1:4];
   logic [2:0] mc [1:4];
   logic [31:0] mepc;
   logic [2:0]  mcause;
   logic        last_take;
   logic [2:0]  last_take_cause;

   always #4 clk = ~clk;

   xcpt_tracker #(.PC_W(PC_W), .VECTOR(VEC)) u_xcpt_tracker (
      .clk(clk), .rst_n(rst_n), .if_valid(if_valid), .if_pc(if_pc),
      .if_itlb_fault(if_itlb_fault), .irq_level(irq_level), .id_illegal(id_illegal),
      .ex_overflow(ex_overflow), .ex_branch(ex_branch), .ex_target(ex_target),
      .mem_dtlb_fault(mem_dtlb_fault), .mem_wr_ok(mem_wr_ok), .wb_wr_ok(wb_wr_ok),
      .xc_take(xc_take), .xc_epc(xc_epc), .xc_cause(xc_cause),
      .redir_valid(redir_valid), .redir_pc(redir_pc));

   function automatic logic [2:0] merge(input logic [2:0] held, input logic [2:0] r);
      return (held != 3'd0) ? held : r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int i = 1; i <= 4; i++) begin mv[i] = 0; mpc[i] = 0; mc[i] = 0; end
      mepc = 0; mcause = 0;
   endtask

   task automatic step(input logic fv, input logic [31:0] fpc, input logic itlb,
                       input logic irq, input logic ill, input logic ovf,
                       input logic br, input logic [31:0] tgt, input logic dtlb);
      logic e_take, e_br, e_mem, e_wb;
      logic [2:0] c0;
      @(negedge clk);
      if_valid = fv; if_pc = fpc; if_itlb_fault = itlb; irq_level = irq;
      id_illegal = ill; ex_overflow = ovf; ex_branch = br; ex_target = tgt;
      mem_dtlb_fault = dtlb;
      #1;
      e_take = mv[4] && mc[4] != 0;
      e_br   = br && mv[2] && mc[2] == 0;
      e_mem  = mv[3] && mc[3] == 0 && !dtlb && !e_take;
      e_wb   = mv[4] && mc[4] == 0;
      chk("R3 take", {31'd0, xc_take}, {31'd0, e_take});
      chk("R5,R10 redir_valid", {31'd0, redir_valid}, {31'd0, e_take || e_br});
      if (e_take || e_br) chk("R5,R10 redir_pc", redir_pc, e_take ? VEC : tgt);
      chk("R9 mem_wr_ok", {31'd0, mem_wr_ok}, {31'd0, e_mem});
      chk("R6,R9 wb_wr_ok", {31'd0, wb_wr_ok}, {31'd0, e_wb});
      chk("R4 epc", xc_epc, mepc);
      chk("R2,R4 cause", {29'd0, xc_cause}, {29'd0, mcause});
      last_take = e_take; last_take_cause = mc[4];
      @(posedge clk);
      if (e_take) begin
         mepc = mpc[4]; mcause = mc[4];
         for (int i = 1; i <= 4; i++) begin mv[i] = 0; mc[i] = 0; end
      end else begin
         mv[4] = mv[3]; mpc[4] = mpc[3]; mc[4] = mv[3] ? merge(mc[3], dtlb ? 3'd4 : 3'd0) : 3'd0;
         mv[3] = mv[2]; mpc[3] = mpc[2]; mc[3] = mv[2] ? merge(mc[2], ovf ? 3'd3 : 3'd0) : 3'd0;
         if (e_br) begin
            mv[2] = 0; mc[2] = 0; mv[1] = 0; mc[1] = 0;
         end else begin
            mv[2] = mv[1]; mpc[2] = mpc[1]; mc[2] = mv[1] ? merge(mc[1], ill ? 3'd2 : 3'd0) : 3'd0;
            c0 = irq ? 3'd5 : (itlb ? 3'd1 : 3'd0);
            mv[1] = fv || irq; mpc[1] = fpc; mc[1] = (fv || irq) ? c0 : 3'd0;
         end
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int irq_count;
      logic [31:0] pc;
      void'($urandom(32'h5eed));
      model_reset();
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk); #1;
      chk("R1 take", {31'd0, xc_take}, 0);
      chk("R1 redir", {31'd0, redir_valid}, 0);
      chk("R1 writes", {30'd0, mem_wr_ok, wb_wr_ok}, 0);
      chk("R1 epc", xc_epc, 0);
      chk("R1 cause", {29'd0, xc_cause}, 0);
      rst_n = 1;
      idle(1);

      // R7: younger B illegal in decode before older A faults in memory
      step(1, 32'h100, 0, 0, 0, 0, 0, 0, 0);   // A fetched
      step(1, 32'h104, 0, 0, 0, 0, 0, 0, 0);   // B fetched, A in decode
      step(1, 32'h108, 0, 0, 1, 0, 0, 0, 0);   // B in decode: illegal
      step(0, 0, 0, 0, 0, 0, 0, 0, 1);         // A in memory: data fault
      step(0, 0, 0, 0, 0, 0, 0, 0, 0);         // A at write-back: take
      chk("R7 take of oldest", {31'd0, last_take}, 1);
      idle(1);
      chk("R7 epc is oldest", xc_epc, 32'h100);
      chk("R7 cause is data fault", {29'd0, xc_cause}, 4);
      idle(4);
      chk("R7 younger never taken", xc_epc, 32'h100);

      // R2: first cause sticks (fetch fault, then overflow)
      step(1, 32'h200, 1, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0, 0, 1);
      step(0, 0, 0, 0, 0, 0, 1, 32'h400, 0);   // R5: branch at take cycle
      chk("R3 take on fourth edge", {31'd0, last_take}, 1);
      idle(1);
      chk("R2 first cause kept", {29'd0, xc_cause}, 1);

      // R10: branch kills fetch and decode
      step(1, 32'h300, 0, 0, 0, 0, 0, 0, 0);
      step(1, 32'h304, 0, 0, 0, 0, 0, 0, 0);
      step(1, 32'h308, 0, 0, 1, 0, 1, 32'h500, 0); // 300 in EX branches
      idle(5);
      chk("R10 killed younger not taken", xc_epc, 32'h200);

      // R8: held interrupt reinjected after flush
      irq_count = 0;
      for (int i = 0; i < 10; i++) begin
         step(1, 32'h600 + i * 4, 0, 1, 0, 0, 0, 0, 0);
         if (last_take && last_take_cause == 3'd5) irq_count++;
      end
      chk("R8 interrupt takes while held", irq_count, 2);
      idle(1);
      chk("R8 cause is interrupt", {29'd0, xc_cause}, 5);
      idle(5);

      // random traffic
      pc = 32'h1000;
      for (int n = 0; n < 3000; n++) begin
         logic irq_r;
         irq_r = ($urandom % 40) == 0;
         step(($urandom % 4) != 0, pc, ($urandom % 24) == 0, irq_r,
              ($urandom % 20) == 0, ($urandom % 20) == 0, ($urandom % 12) == 0,
              $urandom & 32'hffff_fffc, ($urandom % 20) == 0);
         pc = pc + 4;
      end
      idle(6);
      finish_run();
   end
endmodule